// File: doc/BRIEF.md
# Guest Control-Register Shadow Read Mux

This block produces the value a guest observes when it reads control register 0 or the machine-status word while running under virtualization. For every bit position, a guest/host mask decides whether the guest sees the real register bit or the matching bit of a host-owned read shadow. The shadow bit is passed through exactly as stored, so the guest may see bits set that the real register can never hold.

The result is then shaped by the destination kind. A memory destination receives a 16-bit value and a two-byte write enable. A 16-bit register keeps its previous upper 48 bits. A 32-bit register has its upper half cleared. A 64-bit register takes the full per-bit selection. A request strobe loads all inputs, and one cycle later the block presents the registered result together with a valid strobe.

Top module: `guest_cr_read_mux`

## Requirements
- R1: For a 64-bit register destination (dst_kind_i = 3), each result bit i is read_shadow_i[i] when guest_mask_i[i] is 1, and host_cr_i[i] when it is 0.
- R2: With dst_kind_i = 3, an all-zero mask returns host_cr_i unchanged, and an all-one mask returns read_shadow_i unchanged.
- R3: For a memory destination (dst_kind_i = 0), result bits 15:0 are the per-bit selection, bits 63:16 are zero, and byte_en_o is 8'h03, where bit b enables byte lane b and lane 0 holds bits 7:0.
- R4: For a 16-bit register destination (dst_kind_i = 1), result bits 63:16 equal prior_dst_i[63:16] and bits 15:0 are the per-bit selection. Mask and shadow bits 63:16 have no effect on the result.
- R5: For a 32-bit register destination (dst_kind_i = 2), result bits 31:0 are the per-bit selection and bits 63:32 are zero.
- R6: Shadow bits are not filtered. With host_cr_i zero and an all-one mask, every set shadow bit that falls inside the destination width appears in the result.
- R7: valid_o is high in the cycle after a cycle with req_i high, and low otherwise. result_o and byte_en_o hold their values while no request is accepted.
- R8: While rst_ni is low, valid_o, result_o and byte_en_o are all zero.
- R9: For every register destination (dst_kind_i = 1, 2 or 3), byte_en_o is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; the inputs are loaded on this edge |
| dst_kind_i | input | 2 | Destination kind: 0 memory, 1 reg16, 2 reg32, 3 reg64 |
| host_cr_i | input | 64 | Real control register value |
| guest_mask_i | input | 64 | Guest/host mask; 1 selects the shadow bit |
| read_shadow_i | input | 64 | Read shadow value |
| prior_dst_i | input | 64 | Prior contents of the destination register |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| result_o | output | 64 | Value to write back |
| byte_en_o | output | 8 | Byte-lane write enables for the result |

## Verification
The in-module assertions check on every cycle that the valid strobe follows each request by one cycle, that outputs hold between requests, and that the width rules apply to each result: zeroed upper halves for 32-bit and memory destinations, preserved upper bits for 16-bit destinations, the memory byte enable, and pass-through of the real register when the mask is zero. The bench scenarios cover the per-bit mixing under varied masks, the fact that upper mask and shadow bits have no effect on narrow destinations, unfiltered shadow bits, and back-to-back requests compared against an independent model.

// File: rtl/cr_shadow_pkg.sv
package cr_shadow_pkg;

  typedef enum logic [1:0] {
    DST_MEM = 2'd0,
    DST_R16 = 2'd1,
    DST_R32 = 2'd2,
    DST_R64 = 2'd3
  } dst_kind_e;

endpackage

// File: rtl/cr_bit_select.sv
module cr_bit_select #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] host_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] shadow_i,
  output logic [WIDTH-1:0] sel_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sel_o[i] = mask_i[i] ? shadow_i[i] : host_i[i];
  end

endmodule

// File: rtl/cr_width_shape.sv
module cr_width_shape
  import cr_shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned WORD_LANES = WORD_W / 8
) (
  input  dst_kind_e           kind_i,
  input  logic [DATA_W-1:0]   sel_i,
  input  logic [DATA_W-1:0]   prior_i,
  output logic [DATA_W-1:0]   value_o,
  output logic [LANES-1:0]    be_o
);

  always_comb begin
    value_o = '0;
    unique case (kind_i)
      DST_MEM: value_o[WORD_W-1:0] = sel_i[WORD_W-1:0];
      DST_R16: value_o = {prior_i[DATA_W-1:WORD_W], sel_i[WORD_W-1:0]};
      DST_R32: value_o[HALF_W-1:0] = sel_i[HALF_W-1:0];
      DST_R64: value_o = sel_i;
      default: value_o = '0;
    endcase
  end

  // memory stores only the low word lanes; registers are written whole
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    if (b < WORD_LANES) begin : g_low
      assign be_o[b] = 1'b1;
    end else begin : g_high
      assign be_o[b] = (kind_i != DST_MEM);
    end
  end

endmodule

// File: rtl/guest_cr_read_mux.sv
module guest_cr_read_mux
  import cr_shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        dst_kind_i,
  input  logic [DATA_W-1:0] host_cr_i,
  input  logic [DATA_W-1:0] guest_mask_i,
  input  logic [DATA_W-1:0] read_shadow_i,
  input  logic [DATA_W-1:0] prior_dst_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [LANES-1:0]  byte_en_o
);

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] shaped;
  logic [LANES-1:0]  shaped_be;
  dst_kind_e         kind;

  assign kind = dst_kind_e'(dst_kind_i);

  cr_bit_select #(.WIDTH(DATA_W)) i_bit_select (
    .host_i  (host_cr_i),
    .mask_i  (guest_mask_i),
    .shadow_i(read_shadow_i),
    .sel_o   (sel)
  );

  cr_width_shape #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_width_shape (
    .kind_i (kind),
    .sel_i  (sel),
    .prior_i(prior_dst_i),
    .value_o(shaped),
    .be_o   (shaped_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      byte_en_o <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        result_o  <= shaped;
        byte_en_o <= shaped_be;
      end
    end
  end

  // R7
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(req_i));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> ($stable(result_o) && $stable(byte_en_o)));

  // R3
  mem_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_kind_i) == DST_MEM) |->
      (byte_en_o == LANES'(3) && result_o[DATA_W-1:WORD_W] == '0));

  // R5
  r32_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_kind_i) == DST_R32) |-> result_o[DATA_W-1:HALF_W] == '0);

  // R4
  r16_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_kind_i) == DST_R16) |->
      result_o[DATA_W-1:WORD_W] == $past(prior_dst_i[DATA_W-1:WORD_W]));

  // R2
  zero_mask_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_kind_i) == DST_R64 && $past(guest_mask_i) == '0) |->
      result_o == $past(host_cr_i));

  // R9
  reg_be_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dst_kind_i) != DST_MEM) |-> &byte_en_o);

endmodule

// File: tb/test_guest_cr_read_mux.sv
module test_guest_cr_read_mux;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] value;
    logic [7:0]  be;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  dst_kind_i = '0;
  logic [63:0] host_cr_i = '0, guest_mask_i = '0, read_shadow_i = '0, prior_dst_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [7:0]  byte_en_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb[$];
  logic [63:0] last_val = '0;
  logic [7:0]  last_be = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  guest_cr_read_mux i_guest_cr_read_mux (
    .clk_i, .rst_ni, .req_i, .dst_kind_i, .host_cr_i, .guest_mask_i,
    .read_shadow_i, .prior_dst_i, .valid_o, .result_o, .byte_en_o
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] k, input logic [63:0] h, m, s, p, input string tag);
    exp_t e;
    logic [63:0] mix;
    mix = (h & ~m) | (s & m);
    e.tag = tag;
    case (k)
      2'd0: begin e.value = {48'h0, mix[15:0]}; e.be = 8'h03; end
      2'd1: begin e.value = {p[63:16], mix[15:0]}; e.be = 8'hFF; end
      2'd2: begin e.value = {32'h0, mix[31:0]}; e.be = 8'hFF; end
      default: begin e.value = mix; e.be = 8'hFF; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [1:0] k, input logic [63:0] h, m, s, p, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; dst_kind_i = k; host_cr_i = h; guest_mask_i = m;
    read_shadow_i = s; prior_dst_i = p;
    sb.push_back(model(k, h, m, s, p, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      host_cr_i = ~host_cr_i; guest_mask_i = ~guest_mask_i; dst_kind_i = ~dst_kind_i;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 valid without request", 64'(valid_o), 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result_o === e.value, {e.tag, " result"}, result_o, e.value);
          check(byte_en_o === e.be, {e.tag, " byte_en"}, 64'(byte_en_o), 64'(e.be));
          last_val = result_o;
          last_be = byte_en_o;
        end
      end else if (total > 1) begin
        check(result_o === last_val && byte_en_o === last_be, "R7 hold while idle",
              result_o, last_val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] h, m, s, p;
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === '0 && byte_en_o === '0, "R8 reset state",
          result_o, 64'h0);
    rst_ni = 1'b1;

    // R1 mixed masks on reg64
    drive(2'd3, 64'h0000_0000_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF, 64'hAAAA_5555_AAAA_5555, 64'h0, "R1 mix a");
    drive(2'd3, 64'h8000_0011_6000_0033, 64'hF0F0_F0F0_0F0F_0F0F, 64'h1234_5678_9ABC_DEF0, 64'h0, "R1 mix b");
    // R2 extremes
    drive(2'd3, 64'h8005_0033_6001_0031, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R2 zero mask");
    drive(2'd3, 64'h8005_0033_6001_0031, '1, 64'h0BAD_F00D_CAFE_1234, 64'h0, "R2 ones mask");
    idle(2);
    // R3 memory
    drive(2'd0, 64'hFFFF_FFFF_FFFF_0F0F, 64'hFFFF_FFFF_0000_FF00, 64'hFFFF_FFFF_FFFF_A5A5, 64'hDEAD_BEEF_DEAD_BEEF, "R3 memory");
    // R4 reg16: upper mask/shadow differ but must not matter
    drive(2'd1, 64'h0000_0000_0000_1111, 64'hFFFF_0000_FFFF_00FF, 64'hFFFF_FFFF_FFFF_2222, 64'hCAFE_BABE_0123_9999, "R4 reg16 a");
    drive(2'd1, 64'h0000_0000_0000_1111, 64'h0000_FFFF_0000_00FF, 64'h1111_0000_0000_2222, 64'hCAFE_BABE_0123_9999, "R4 reg16 b");
    // R5 reg32
    drive(2'd2, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_ABCD_0000, 64'h0, "R5 reg32");
    // R6 unfiltered shadow
    drive(2'd3, 64'h0, '1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 shadow reg64");
    drive(2'd0, 64'h0, '1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 shadow memory");
    idle(3);
    // R9 byte enables across register kinds plus pseudo-random traffic
    for (int i = 0; i < 40; i++) begin
      h = {$urandom, $urandom}; m = {$urandom, $urandom};
      s = {$urandom, $urandom}; p = {$urandom, $urandom};
      drive(2'(i % 4), h, m, s, p, "R9 R1 random");
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R7 all results delivered", 64'(sb.size()), 64'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule